// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block is the three-wire programming port of a clock synthesizer. A host shifts a 15-bit control word in over a serial clock and data line. A load strobe then moves the word into the control registers that steer the feedback divider, the output divider, the spread-spectrum modulator and a test pin. The PLL and the divider datapaths sit outside. Their feedback-divider tap and synthesized-clock tap enter as plain inputs, so that the test pin can route either of them out.

All three serial pins are slow compared with the system clock. Each pin passes through a two-flop synchronizer, and its edges are detected in the system-clock domain. The load strobe has three roles. Its rising edge copies the shift register into the control registers. Its falling edge freezes them. While it stays high, every serial clock edge shifts the register and feeds the new contents straight through to the controls. A separate master reset input is passed to the divider datapaths and leaves the configuration untouched.

Top module: `synth_serial_cfg`

## Requirements
- R1: After rst_n is released, the control outputs hold their power-up values: m_div = 192, n_code = 3'b000 (divide by 2), ssc_en = 0 and test_mode = 2'b01. The shift register is cleared, so test_out is 0.
- R2: While ser_load is low, each rising edge of ser_clk shifts ser_data into the low end of the 15-bit shift register. The first bit sent ends up in the top stage after 15 edges. A word is sent in time order: test bit 1, test bit 0, output-divider code bits 2..0, feedback value bits 8..0, then the spread enable bit.
- R3: While ser_load stays low, shifting leaves m_div, n_code, ssc_en and test_mode unchanged.
- R4: A rising edge on ser_load copies the shift register into the controls. Register bits [14:13] go to test_mode, [12:10] to n_code, [9:1] to m_div and [0] to ssc_en.
- R5: After ser_load falls, the controls keep the values they held at the falling edge, whatever ser_clk and ser_data then do.
- R6: While ser_load is high, each rising ser_clk edge shifts the register, and the controls take the newly shifted contents in that same step.
- R7: When test_mode = 2'b00, test_out is held low.
- R8: When test_mode = 2'b01, test_out shows the top stage of the shift register, so a bit reappears on it 15 serial clock edges after it was shifted in.
- R9: test_mode = 2'b10 routes fb_tap to test_out, and test_mode = 2'b11 routes fout_tap to it.
- R10: m_ok is 1 exactly when m_div lies between 120 and 240, both limits included.
- R11: div_rst follows mr. The master reset has no effect on the control registers or the shift register.
- R12: Each serial action takes effect within three system-clock cycles of the input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, loads the default controls |
| mr | input | 1 | Master reset for the divider datapaths |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Transfer / latch / pass-through strobe |
| fb_tap | input | 1 | Feedback divider output tap |
| fout_tap | input | 1 | Synthesized output clock tap |
| m_div | output | 9 | Feedback divider value |
| n_code | output | 3 | Output divider code |
| ssc_en | output | 1 | Spread-spectrum enable |
| test_mode | output | 2 | Test pin selection |
| test_out | output | 1 | Test pin |
| m_ok | output | 1 | Feedback value inside the lock range |
| div_rst | output | 1 | Reset to the divider datapaths |

## Verification
The hardest case to reach is a hidden bit in the top shift stage while the test pin is not showing it. The bench first loads a word with the test bits cleared. With the strobe low, it then shifts fifteen ones, so the top stage holds a 1 while the controls still select the constant-low source. A second hard case is the frozen state after pass-through mode. The bench runs transparent shifting, drops the strobe, and then clocks more bits to show that the controls no longer move.

// File: rtl/synth_serial_cfg.sv
module synth_serial_cfg #(
  parameter int M_W      = 9,
  parameter int N_W      = 3,
  parameter int T_W      = 2,
  parameter int M_RESET  = 192,
  parameter int N_RESET  = 0,
  parameter int T_RESET  = 1,
  parameter int M_MIN    = 120,
  parameter int M_MAX    = 240
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           fb_tap,
  input  logic           fout_tap,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_code,
  output logic           ssc_en,
  output logic [T_W-1:0] test_mode,
  output logic           test_out,
  output logic           m_ok,
  output logic           div_rst
);
  localparam int WORD_W = T_W + N_W + M_W + 1;
  localparam logic [WORD_W-1:0] CTRL_RESET =
    {T_W'(T_RESET), N_W'(N_RESET), M_W'(M_RESET), 1'b0};

  logic [2:0] clk_q, load_q;
  logic [1:0] dat_q;
  logic [WORD_W-1:0] sh, ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= '0;
      load_q <= '0;
      dat_q  <= '0;
    end else begin
      clk_q  <= {clk_q[1:0], ser_clk};
      load_q <= {load_q[1:0], ser_load};
      dat_q  <= {dat_q[0], ser_data};
    end
  end

  wire sclk_rise = clk_q[1] & ~clk_q[2];
  wire load_lvl  = load_q[1];
  wire load_rise = load_q[1] & ~load_q[2];
  wire [WORD_W-1:0] sh_next = {sh[WORD_W-2:0], dat_q[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      ctrl <= CTRL_RESET;
    end else begin
      if (sclk_rise) sh <= sh_next;
      if (load_rise) ctrl <= sh;
      else if (load_lvl && sclk_rise) ctrl <= sh_next;
    end
  end

  assign test_mode = ctrl[WORD_W-1 -: T_W];
  assign n_code    = ctrl[M_W+1 +: N_W];
  assign m_div     = ctrl[1 +: M_W];
  assign ssc_en    = ctrl[0];

  always_comb begin
    case (test_mode)
      2'b00:   test_out = 1'b0;
      2'b01:   test_out = sh[WORD_W-1];
      2'b10:   test_out = fb_tap;
      default: test_out = fout_tap;
    endcase
  end

  assign m_ok    = (m_div >= M_W'(M_MIN)) && (m_div <= M_W'(M_MAX));
  assign div_rst = mr;
endmodule

// File: rtl/synth_serial_cfg_chk.sv
module synth_serial_cfg_chk #(
  parameter int WORD_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              load_lvl,
  input logic              load_rise,
  input logic              dat_s,
  input logic [WORD_W-1:0] sh,
  input logic [WORD_W-1:0] ctrl,
  input logic [1:0]        test_mode,
  input logic              test_out
);
  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !load_lvl) |=> (sh == {$past(sh[WORD_W-2:0]), $past(dat_s)}));
  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_lvl |=> $stable(ctrl));
  // R4
  load_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> (ctrl == $past(sh)));
  // R6
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lvl && !load_rise && sclk_rise) |=> (ctrl == sh));
  // R7
  test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'b00) |-> !test_out);
endmodule

bind synth_serial_cfg synth_serial_cfg_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .load_lvl(load_lvl),
  .load_rise(load_rise), .dat_s(dat_q[1]), .sh(sh), .ctrl(ctrl),
  .test_mode(test_mode), .test_out(test_out)
);

// File: tb/tb_synth_serial_cfg.sv
module tb_synth_serial_cfg;
  logic clk = 0, rst_n = 0, mr = 0;
  logic ser_clk = 0, ser_data = 0, ser_load = 0, fb_tap = 0, fout_tap = 0;
  logic [8:0] m_div;
  logic [2:0] n_code;
  logic ssc_en, test_out, m_ok, div_rst;
  logic [1:0] test_mode;
  int total = 0, bad = 0;
  bit done = 0;
  logic [14:0] sh_m = '0;

  always #10 clk = ~clk;

  synth_serial_cfg dut (
    .clk(clk), .rst_n(rst_n), .mr(mr), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .fb_tap(fb_tap), .fout_tap(fout_tap), .m_div(m_div),
    .n_code(n_code), .ssc_en(ssc_en), .test_mode(test_mode), .test_out(test_out),
    .m_ok(m_ok), .div_rst(div_rst)
  );

  wire [14:0] ctrl_o = {test_mode, n_code, m_div, ssc_en};

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_data = b; tick(4);
    ser_clk = 1;  tick(4);
    ser_clk = 0;  tick(4);
    sh_m = {sh_m[13:0], b};
  endtask

  task automatic send_word(logic [14:0] w);
    for (int i = 14; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic set_load(logic v);
    ser_load = v; tick(5);
  endtask

  task automatic load_word(logic [14:0] w);
    send_word(w); set_load(1); set_load(0);
  endtask

  function automatic logic [14:0] mk(logic [1:0] t, logic [2:0] n, logic [8:0] m, logic s);
    return {t, n, m, s};
  endfunction

  task automatic t_reset();
    check("R1 ctrl", 16'(ctrl_o), 16'(mk(2'b01, 3'b000, 9'd192, 1'b0)));
    check("R1 test_out", 16'(test_out), 16'd0);
    check("R10 default m_ok", 16'(m_ok), 16'd1);
  endtask

  task automatic t_shift_readback();
    logic [14:0] w = 15'h5A3C;
    send_word(w);
    check("R8 top stage", 16'(test_out), 16'(w[14]));
    check("R3 ctrl unchanged", 16'(ctrl_o), 16'(mk(2'b01, 3'b000, 9'd192, 1'b0)));
    send_bit(0);
    check("R8 next bit", 16'(test_out), 16'(w[13]));
    check("R2 shift order", 16'(test_out), 16'(sh_m[14]));
  endtask

  task automatic t_transfer();
    logic [14:0] w = mk(2'b01, 3'b101, 9'd150, 1'b1);
    send_word(w);
    set_load(1);
    check("R4 transfer", 16'(ctrl_o), 16'(w));
    check("R4 fields", 16'({n_code, ssc_en}), 16'({3'b101, 1'b1}));
    set_load(0);
  endtask

  task automatic t_transparent_and_freeze();
    logic [14:0] w = mk(2'b01, 3'b011, 9'd201, 1'b0);
    logic [14:0] saved;
    set_load(1);
    send_bit(w[14]);
    check("R6 first bit", 16'(ctrl_o), 16'(sh_m));
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
    check("R6 full word", 16'(ctrl_o), 16'(w));
    saved = ctrl_o;
    set_load(0);
    for (int i = 0; i < 6; i++) send_bit(1'(i % 2));
    check("R5 frozen", 16'(ctrl_o), 16'(saved));
  endtask

  task automatic t_test_mux();
    load_word(mk(2'b00, 3'b001, 9'd180, 1'b0));
    send_word(15'h7FFF);
    check("R7 low despite top=1", 16'(test_out), 16'd0);
    check("R3 ctrl kept", 16'(test_mode), 16'd0);
    load_word(mk(2'b10, 3'b001, 9'd180, 1'b0));
    fb_tap = 1; tick(1);
    check("R9 fb high", 16'(test_out), 16'd1);
    fb_tap = 0; tick(1);
    check("R9 fb low", 16'(test_out), 16'd0);
    load_word(mk(2'b11, 3'b001, 9'd180, 1'b0));
    fout_tap = 1; fb_tap = 0; tick(1);
    check("R9 fout high", 16'(test_out), 16'd1);
    fout_tap = 0; fb_tap = 1; tick(1);
    check("R9 fout low", 16'(test_out), 16'd0);
    fb_tap = 0;
  endtask

  task automatic t_range();
    int vals [4] = '{119, 120, 240, 241};
    bit exp [4] = '{0, 1, 1, 0};
    for (int i = 0; i < 4; i++) begin
      load_word(mk(2'b00, 3'b000, 9'(vals[i]), 1'b0));
      check("R10 m value", 16'(m_div), 16'(vals[i]));
      check("R10 m_ok", 16'(m_ok), 16'(exp[i]));
    end
  endtask

  task automatic t_mr();
    logic [14:0] saved = ctrl_o;
    mr = 1; tick(3);
    check("R11 div_rst high", 16'(div_rst), 16'd1);
    check("R11 ctrl kept", 16'(ctrl_o), 16'(saved));
    mr = 0; tick(3);
    check("R11 div_rst low", 16'(div_rst), 16'd0);
  endtask

  task automatic t_latency();
    ser_load = 1; tick(3);
    check("R12 transfer within 3", 16'(ctrl_o), 16'(sh_m));
    tick(2); set_load(0);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(3);
    t_reset();
    t_shift_readback();
    t_transfer();
    t_transparent_and_freeze();
    t_test_mux();
    t_range();
    t_mr();
    send_word(mk(2'b01, 3'b010, 9'd222, 1'b1));
    t_latency();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule